// File: doc/BRIEF.md
# Configurable Audio Serial Transmitter

This block sends multichannel audio on serial data pins. A bit clock and a frame clock reach it from outside, from a neighbouring clock generator or from an external master. The block samples both clocks with its own system clock. It launches one data bit on every selected edge of the bit clock. A static control word sets the framing. In stereo framing each of four data pins carries two channels in a 64-bit frame. In TDM framing the first pin carries all eight channels in a 256-bit frame and the other pins stay low. Each channel slot is 32 bit clocks wide.

A producer offers one frame's worth of 24-bit samples (eight channels) at a time through a valid/ready handshake. The block holds one staged frame. At each frame start it moves the staged frame into the shift source. If nothing is staged, that frame is sent as zeros and the block flags an underrun. Inside a slot the control word chooses how many bit clocks separate the slot start from the MSB and how many bits of each sample are sent. Every remaining slot position is driven low.

Top module: `serial_audio_tx`

## Requirements
- R1: Frame clock polarity is set by cfg[8]. In word-clock mode a frame starts at the launch edge where the sampled frame clock first equals cfg[8], having not equalled it at the previous launch edge. The even channel of each pin's pair (left) goes out at that level and the odd channel (right) at the other level, so cfg[8]=0 sends left while the frame clock is low.
- R2: cfg[7]=0 makes sdout change only in the system clock cycle after a falling bit-clock edge is sampled. cfg[7]=1 does the same for rising edges. At the opposite edge sdout holds its value.
- R3: Samples are sent MSB first. Bit j of a 24-bit sample, counted from the MSB, goes out at slot position d+j, where d is the MSB delay. A bit that would land past position 31 of the slot is not sent.
- R4: cfg[2:0] sets the MSB delay d in bit clocks: 3'b000 gives 1, 3'b001 gives 0, 3'b010 gives 8, 3'b011 gives 12, 3'b100 gives 16. Every other code gives 1.
- R5: cfg[4:3] sets the sent word length: 2'b00 gives 24, 2'b01 gives 20, 2'b10 gives 16, and 2'b11 gives 24. All slot positions outside the sent bits are 0.
- R6: With cfg[6]=1, sdout[0] carries channels 0 to 7 in order in a 256-bit frame and sdout[3:1] stay 0. With cfg[6]=0, sdout[k] carries channel 2k and then channel 2k+1 in a 64-bit frame. Channel c is smp_data[24c+23:24c].
- R7: With cfg[5]=1 the frame clock is a one-bit-clock pulse. A frame starts at the launch edge where the sampled frame clock is 1 after being 0 at the previous launch edge, and cfg[8] has no effect.
- R8: smp_ready is 1 exactly when no frame is staged. A word accepted on a cycle with smp_valid and smp_ready both 1 is sent in the next frame that starts.
- R9: If no frame is staged when a frame starts, that whole frame is 0 on every pin and underrun is 1 for one system clock cycle. Otherwise underrun stays 0.
- R10: During and after reset, sdout and underrun are 0 and smp_ready is 1. sdout stays 0 until the first frame start, whatever the bit clock does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both serial clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 9 | Static control word (fields in R1, R2, R4 to R7) |
| bclk | input | 1 | Bit clock |
| fclk | input | 1 | Frame clock: word clock or start pulse |
| smp_valid | input | 1 | Producer offers a frame of samples |
| smp_ready | output | 1 | Staging register is empty |
| smp_data | input | 192 | Eight 24-bit samples, channel c at bits 24c+23:24c |
| sdout | output | 4 | Serial data pins |
| underrun | output | 1 | One-cycle flag: a frame started with no staged data |

## Verification
Delay 16 with 24-bit words runs past the slot end, so a design that wraps the excess LSBs into the next slot corrupts its neighbour channel. The reserved delay and length codes catch a design that decodes them to some value other than the defaults. Pulse framing with inverted polarity catches a design that lets polarity steer the pulse detector, which would shift every frame by half. A frame with nothing staged must come out entirely zero with exactly one underrun pulse. A design that replays the previous samples, or pulses the flag more than once, shows up as a data mismatch or a wrong pulse count.

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int CHANS  = 8,
  parameter int PINS   = 4,
  parameter int WORD_W = 24,
  parameter int SLOT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [8:0]              cfg,
  input  logic                    bclk,
  input  logic                    fclk,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [CHANS*WORD_W-1:0] smp_data,
  output logic [PINS-1:0]         sdout,
  output logic                    underrun
);
  localparam int SLOT_LG = $clog2(SLOT_W);
  localparam int CH_LG   = $clog2(CHANS);
  localparam int POS_W   = SLOT_LG + CH_LG;
  localparam int CPP     = CHANS / PINS;
  localparam int CPP_LG  = $clog2(CPP);
  localparam int LW      = SLOT_LG + 1;
  localparam int BUF_W   = CHANS * WORD_W;
  localparam logic [POS_W-1:0] ST_MASK = POS_W'(SLOT_W * CPP - 1);

  wire [2:0] dly_code = cfg[2:0];
  wire [1:0] len_code = cfg[4:3];
  wire       pulse_fs = cfg[5];
  wire       tdm      = cfg[6];
  wire       on_rise  = cfg[7];
  wire       left_lvl = cfg[8];

  logic             bclk_q, fclk_last, locked, full;
  logic [POS_W-1:0] pos;
  logic [BUF_W-1:0] stage, active;
  logic [LW-1:0]    dly, wl;

  always_comb begin
    case (dly_code)
      3'd1:    dly = '0;
      3'd2:    dly = LW'(8);
      3'd3:    dly = LW'(12);
      3'd4:    dly = LW'(16);
      default: dly = LW'(1);
    endcase
    case (len_code)
      2'd1:    wl = LW'(WORD_W - 4);
      2'd2:    wl = LW'(WORD_W - 8);
      default: wl = LW'(WORD_W);
    endcase
  end

  wire launch = on_rise ? (bclk & ~bclk_q) : (~bclk & bclk_q);
  wire start  = pulse_fs ? (fclk & ~fclk_last)
                         : ((fclk == left_lvl) && (fclk_last != left_lvl));
  wire [POS_W-1:0] pos_inc = pos + 1'b1;
  wire [POS_W-1:0] pos_nx  = start ? '0 : (tdm ? pos_inc : (pos_inc & ST_MASK));
  wire [BUF_W-1:0] cur_buf = start ? (full ? stage : '0) : active;
  wire             live    = locked | start;

  wire [LW-1:0] bpos    = {1'b0, pos_nx[SLOT_LG-1:0]};
  wire [LW-1:0] j       = bpos - dly;
  wire          in_word = (bpos >= dly) && (j < wl);

  assign smp_ready = ~full;

  logic [PINS-1:0] nbit;
  always_comb begin
    logic [CH_LG-1:0]  ch;
    logic [WORD_W-1:0] word;
    int                idx;
    for (int k = 0; k < PINS; k++) begin
      ch   = tdm ? pos_nx[POS_W-1:SLOT_LG]
                 : CH_LG'(k * CPP) + CH_LG'(pos_nx[SLOT_LG +: CPP_LG]);
      word = cur_buf[int'(ch)*WORD_W +: WORD_W];
      idx  = in_word ? (WORD_W - 1 - int'(j)) : 0;
      nbit[k] = live && in_word && (!tdm || k == 0) && word[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q    <= bclk;
      fclk_last <= fclk;
      pos       <= '0;
      locked    <= 1'b0;
      full      <= 1'b0;
      stage     <= '0;
      active    <= '0;
      sdout     <= '0;
      underrun  <= 1'b0;
    end else begin
      bclk_q   <= bclk;
      underrun <= 1'b0;
      if (launch) begin
        fclk_last <= fclk;
        pos       <= pos_nx;
        sdout     <= nbit;
        if (start) begin
          locked   <= 1'b1;
          active   <= cur_buf;
          underrun <= ~full;
          full     <= 1'b0;
        end
      end
      if (smp_valid && smp_ready) begin
        stage <= smp_data;
        full  <= 1'b1;
      end
    end
  end

  assert_launch_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(sdout));
  assert_tdm_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tdm && launch) |=> (sdout[PINS-1:1] == '0));
  assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
  assert_underrun_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);
  assert_underrun_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (sdout == '0));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (sdout == '0));
endmodule

// File: tb/serial_audio_tx_bench.sv
module serial_audio_tx_bench;
  logic         clk = 0, rst_n = 0, bclk = 0, fclk = 0, smp_valid = 0;
  logic [8:0]   cfg = '0;
  logic [191:0] smp_data = '0;
  logic         smp_ready, underrun;
  logic [3:0]   sdout;
  int errors = 0, checks = 0, urun_cnt = 0, stab_bad = 0;
  logic [3:0] cap [0:511];

  serial_audio_tx u_serial_audio_tx (.clk(clk), .rst_n(rst_n), .cfg(cfg), .bclk(bclk),
    .fclk(fclk), .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .sdout(sdout), .underrun(underrun));

  always #5 clk = ~clk;
  always @(negedge clk) if (rst_n && underrun) urun_cnt++;

  // {cfg[8:0], expected delay, expected word length}
  localparam logic [18:0] VEC [16] = '{
    {9'b0_0_0_0_00_000, 5'd1,  5'd24}, {9'b0_0_0_0_00_001, 5'd0,  5'd24},
    {9'b0_1_0_0_01_010, 5'd8,  5'd20}, {9'b1_0_0_0_10_011, 5'd12, 5'd16},
    {9'b1_1_0_0_00_100, 5'd16, 5'd24}, {9'b0_0_0_0_11_101, 5'd1,  5'd24},
    {9'b0_0_0_1_00_001, 5'd0,  5'd24}, {9'b1_1_0_1_10_000, 5'd1,  5'd16},
    {9'b0_0_1_0_00_000, 5'd1,  5'd24}, {9'b0_1_1_1_01_001, 5'd0,  5'd20},
    {9'b1_0_1_0_10_100, 5'd16, 5'd16}, {9'b0_0_1_0_11_111, 5'd1,  5'd24},
    {9'b1_0_0_0_01_110, 5'd1,  5'd20}, {9'b0_1_0_0_00_011, 5'd12, 5'd24},
    {9'b1_1_1_1_00_010, 5'd8,  5'd24}, {9'b0_0_0_1_10_100, 5'd16, 5'd16}};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [191:0] mkdata(input int seed);
    logic [191:0] w;
    for (int c = 0; c < 8; c++)
      w[c*24 +: 24] = 24'(seed * 32'h9E3779B1 + c * 32'h7F4A7C15) ^ 24'hC35A97;
    return w;
  endfunction

  function automatic logic exp_bit(input logic [191:0] w, input int pin, input int p,
                                   input logic tdm, input int d, input int wl);
    int ch, b;
    b = p % 32;
    if (tdm) begin
      if (pin != 0) return 1'b0;
      ch = p / 32;
    end else ch = 2 * pin + (p / 32) % 2;
    if (b < d || b - d >= wl) return 1'b0;
    return w[ch*24 + 23 - (b - d)];
  endfunction

  task automatic do_reset(input logic [8:0] c);
    cfg = c; bclk = ~c[7]; fclk = c[5] ? 1'b0 : ~c[8]; smp_valid = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic drive_frames(input int nfr);
    int fl;
    logic s;
    fl = cfg[6] ? 256 : 64;
    for (int f = 0; f < nfr; f++)
      for (int p = 0; p < fl; p++) begin
        @(negedge clk);
        bclk = cfg[7];
        fclk = cfg[5] ? (p == 0) : ((p < fl / 2) ? cfg[8] : ~cfg[8]);
        @(negedge clk);
        cap[f*fl + p] = sdout;
        @(negedge clk);
        bclk = ~cfg[7];
        @(negedge clk);
        if (sdout != cap[f*fl + p]) stab_bad++;
      end
  endtask

  task automatic push(input logic [191:0] d);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1; smp_data = d;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic compare(input int f, input logic [191:0] w, input int d,
                         input int wl, input string tag);
    int fl, mm;
    fl = cfg[6] ? 256 : 64;
    for (int pin = 0; pin < 4; pin++) begin
      mm = 0;
      for (int p = 0; p < fl; p++)
        if (cap[f*fl + p][pin] !== exp_bit(w, pin, p, cfg[6], d, wl)) mm++;
      check(mm == 0, tag, $sformatf("cfg %b frame %0d pin %0d mismatched bits", cfg, f, pin),
            mm, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [191:0] a, b;
    // R10 reset state
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(sdout == 0 && underrun == 0 && smp_ready == 1, "R10", "reset outputs",
          {sdout, underrun, smp_ready}, 1);

    // vector table: R1 R3 R4 R5 R6 R7 data, R2 stability, R9 no false underrun
    for (int v = 0; v < 16; v++) begin
      a = mkdata(2 * v + 1); b = mkdata(2 * v + 2);
      do_reset(VEC[v][18:10]);
      push(a);
      stab_bad = 0; urun_cnt = 0;
      fork
        drive_frames(2);
        push(b);
      join
      compare(0, a, int'(VEC[v][9:5]), int'(VEC[v][4:0]), "R1 R3 R4 R5 R6 R7");
      compare(1, b, int'(VEC[v][9:5]), int'(VEC[v][4:0]), "R1 R3 R4 R5 R6 R7 R8");
      check(stab_bad == 0, "R2", "sdout moved on non-launch edge", stab_bad, 0);
      check(urun_cnt == 0, "R9", "underrun with data staged", urun_cnt, 0);
    end

    // R10: no frame start yet, bit clock running -> silent; R8 ready drops on accept
    do_reset(9'b0);
    push(mkdata(99));
    check(smp_ready == 0, "R8", "ready after accept", smp_ready, 0);
    stab_bad = 0;
    for (int p = 0; p < 40; p++) begin
      @(negedge clk); bclk = 1'b0;
      @(negedge clk); if (sdout != 0) stab_bad++;
      @(negedge clk); bclk = 1'b1;
      @(negedge clk);
    end
    check(stab_bad == 0, "R10", "sdout before first frame start", stab_bad, 0);

    // R9: second frame has nothing staged
    a = mkdata(77);
    do_reset(9'b0_0_0_0_00_000);
    push(a);
    urun_cnt = 0;
    drive_frames(2);
    compare(0, a, 1, 24, "R9");
    compare(1, '0, 1, 24, "R9");
    check(urun_cnt == 1, "R9", "underrun pulse count", urun_cnt, 1);
    check(smp_ready == 1, "R8", "ready after staged frame consumed", smp_ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule